// File: doc/BRIEF.md
# Masked Multicast Destination Filter

This block decides whether a received Ethernet frame should be kept, based only on its 48-bit destination address. It holds a small table of programmable entries. Each entry has an address, a bit mask and an enable bit. An address bit takes part in the comparison only where the entry's mask bit is 1, so a single entry can cover a whole range of group addresses. For multicast destinations, the frame is kept only when at least one enabled entry matches. Other destinations are not judged here: they are passed on as accepted, and other logic handles them.

Software writes the table through a flat register port. Each 48-bit value is split into a low 32-bit word and a high 16-bit word. One further register collects all the enable bits. A combinational read port returns any stored value. The receive path presents a destination address together with a valid strobe. The decision appears, registered, on the next clock.

Top module: `mcast_addr_screen`

## Requirements
- R1: After reset, every stored address, mask and enable bit is zero, and the decision outputs `dec_valid` and `dec_accept` are low.
- R2: Register index layout for the default of eight entries (`idx[5]` selects the enable register, `idx[4:3]` selects the field and `idx[2:0]` selects the entry):
  - Index n writes bits 31:0 of entry n's address.
  - Index 8+n writes address bits 47:32 from data bits 15:0.
  - Index 16+n writes bits 31:0 of the mask.
  - Index 24+n writes mask bits 47:32 from data bits 15:0.
  - Index 32 writes the enable register, where data bit n enables entry n.
  - Data bits above a field's width are dropped, and read back as zero.
- R3: A mask bit of 1 makes the matching address bit take part in the comparison. A mask bit of 0 makes that bit a don't-care.
- R4: A multicast destination is accepted when it matches at least one enabled entry under that entry's mask. Otherwise it is rejected.
- R5: A destination whose bit 40 is 0 is not multicast (bit 40 is the group bit, the low bit of the first octet). Such a destination is always accepted, whatever the table holds.
- R6: While the enable register is zero, every multicast destination is rejected.
- R7: `dec_valid` is `da_valid` delayed by exactly one clock. `dec_accept` is low whenever `dec_valid` is low.
- R8: A register write issued in the same cycle as an address strobe does not affect that strobe's decision. It does apply from the next strobe onward.
- R9: Consider entry 0 with address high 0x0100, address low 0x5E000000, both mask words all ones, and only enable bit 0 set. With this table, 01:00:5E:00:00:00 is accepted and 01:00:5E:00:00:01 is rejected.
- R10: An entry whose enable bit is 0 never causes acceptance, even when its address and mask match the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_idx | input | 6 | Register index for writes |
| cfg_wdata | input | 32 | Write data |
| rd_idx | input | 6 | Register index for readback |
| rd_data | output | 32 | Readback data, combinational |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first octet in bits 47:40 |
| dec_valid | output | 1 | Decision strobe, one clock after `da_valid` |
| dec_accept | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
The checker follows several properties on every clock:
- `dec_valid` tracks `da_valid` with a one-cycle delay.
- No accept is raised without a decision.
- A non-multicast strobe always produces an accept.
- An empty enable register or an absence of entry hits always produces a reject.

Some behaviour can only be shown by the bench's directed scenarios:
- the register layout;
- the field truncation;
- the mask don't-care ranges at their edges;
- the disabled-but-matching entry;
- the ordering of a write against a strobe in the same cycle.

// File: rtl/mcast_screen_pkg.sv
package mcast_screen_pkg;

   // Field selector carried in the register index, just above the entry number
   typedef enum logic [1:0] {
      FLD_ADDR_LO = 2'd0,
      FLD_ADDR_HI = 2'd1,
      FLD_MASK_LO = 2'd2,
      FLD_MASK_HI = 2'd3
   } field_e;

endpackage

// File: rtl/mcast_cfg_regs.sv
module mcast_cfg_regs
   import mcast_screen_pkg::*;
#(
   parameter int N_ENT  = 8,
   parameter int ADDR_W = 48,
   parameter int DATA_W = 32,
   localparam int ENT_W = $clog2(N_ENT),
   localparam int IDX_W = ENT_W + 3,
   localparam int HI_W  = ADDR_W - DATA_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic [IDX_W-1:0]               cfg_idx,
   input  logic [DATA_W-1:0]              cfg_wdata,
   input  logic [IDX_W-1:0]               rd_idx,
   output logic [DATA_W-1:0]              rd_data,
   output logic [N_ENT-1:0][ADDR_W-1:0]   ent_addr,
   output logic [N_ENT-1:0][ADDR_W-1:0]   ent_mask,
   output logic [N_ENT-1:0]               ent_en
);

   // Decode of the write index
   logic             wr_is_en;
   field_e           wr_fld;
   logic [ENT_W-1:0] wr_ent;

   assign wr_is_en = cfg_idx[IDX_W-1];
   assign wr_fld   = field_e'(cfg_idx[ENT_W+1:ENT_W]);
   assign wr_ent   = cfg_idx[ENT_W-1:0];

   // Per-entry storage
   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic sel;
      assign sel = cfg_we && !wr_is_en && (wr_ent == ENT_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_addr[e] <= '0;
            ent_mask[e] <= '0;
         end else if (sel) begin
            case (wr_fld)
               FLD_ADDR_LO: ent_addr[e][DATA_W-1:0]      <= cfg_wdata;
               FLD_ADDR_HI: ent_addr[e][ADDR_W-1:DATA_W] <= cfg_wdata[HI_W-1:0];
               FLD_MASK_LO: ent_mask[e][DATA_W-1:0]      <= cfg_wdata;
               FLD_MASK_HI: ent_mask[e][ADDR_W-1:DATA_W] <= cfg_wdata[HI_W-1:0];
               default: ;
            endcase
         end
      end
   end

   // Enable register
   always_ff @(posedge clk) begin
      if (!rst_n)
         ent_en <= '0;
      else if (cfg_we && wr_is_en)
         ent_en <= cfg_wdata[N_ENT-1:0];
   end

   // Combinational readback
   field_e           rd_fld;
   logic [ENT_W-1:0] rd_ent;

   assign rd_fld = field_e'(rd_idx[ENT_W+1:ENT_W]);
   assign rd_ent = rd_idx[ENT_W-1:0];

   always_comb begin
      rd_data = '0;
      if (rd_idx[IDX_W-1]) begin
         rd_data[N_ENT-1:0] = ent_en;
      end else begin
         for (int e = 0; e < N_ENT; e++) begin
            if (rd_ent == ENT_W'(e)) begin
               case (rd_fld)
                  FLD_ADDR_LO: rd_data             = ent_addr[e][DATA_W-1:0];
                  FLD_ADDR_HI: rd_data[HI_W-1:0]   = ent_addr[e][ADDR_W-1:DATA_W];
                  FLD_MASK_LO: rd_data             = ent_mask[e][DATA_W-1:0];
                  FLD_MASK_HI: rd_data[HI_W-1:0]   = ent_mask[e][ADDR_W-1:DATA_W];
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/mcast_entry_cmp.sv
module mcast_entry_cmp #(
   parameter int ADDR_W = 48
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [ADDR_W-1:0] care_mask,
   input  logic [ADDR_W-1:0] da,
   output logic              hit
);

   logic [ADDR_W-1:0] diff;

   // Only bits marked in the mask may disagree to spoil a hit
   assign diff = (da ^ ref_addr) & care_mask;
   assign hit  = en && (diff == '0);

endmodule

// File: rtl/mcast_decide.sv
module mcast_decide #(
   parameter int N_ENT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             da_valid,
   input  logic             is_mcast,
   input  logic [N_ENT-1:0] hits,
   output logic             dec_valid,
   output logic             dec_accept
);

   logic keep;

   assign keep = !is_mcast || (|hits);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_valid  <= da_valid;
         dec_accept <= da_valid && keep;
      end
   end

endmodule

// File: rtl/mcast_addr_screen.sv
module mcast_addr_screen #(
   parameter int N_ENT  = 8,
   parameter int ADDR_W = 48,
   parameter int DATA_W = 32,
   parameter int MC_BIT = 40,
   localparam int ENT_W = $clog2(N_ENT),
   localparam int IDX_W = ENT_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              da_valid,
   input  logic [ADDR_W-1:0] da,
   output logic              dec_valid,
   output logic              dec_accept
);

   // Elaboration-time parameter checks
   if (N_ENT < 2 || N_ENT > DATA_W) begin : g_bad_ent
      $error("N_ENT must lie between 2 and DATA_W");
   end
   if (ADDR_W <= DATA_W || ADDR_W > 2 * DATA_W) begin : g_bad_addr
      $error("ADDR_W must exceed DATA_W and fit in two data words");
   end
   if (MC_BIT < 0 || MC_BIT >= ADDR_W) begin : g_bad_mc
      $error("MC_BIT must index a bit of the address");
   end

   logic [N_ENT-1:0][ADDR_W-1:0] ent_addr;
   logic [N_ENT-1:0][ADDR_W-1:0] ent_mask;
   logic [N_ENT-1:0]             entry_en;
   logic [N_ENT-1:0]             hit_vec;

   mcast_cfg_regs #(
      .N_ENT  (N_ENT),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .ent_addr  (ent_addr),
      .ent_mask  (ent_mask),
      .ent_en    (entry_en)
   );

   for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
      mcast_entry_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .en        (entry_en[e]),
         .ref_addr  (ent_addr[e]),
         .care_mask (ent_mask[e]),
         .da        (da),
         .hit       (hit_vec[e])
      );
   end

   mcast_decide #(.N_ENT(N_ENT)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .da_valid   (da_valid),
      .is_mcast   (da[MC_BIT]),
      .hits       (hit_vec),
      .dec_valid  (dec_valid),
      .dec_accept (dec_accept)
   );

endmodule

// File: rtl/mcast_addr_screen_chk.sv
module mcast_addr_screen_chk #(
   parameter int N_ENT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             da_valid,
   input logic             da_mc,
   input logic             dec_valid,
   input logic             dec_accept,
   input logic [N_ENT-1:0] entry_en,
   input logic [N_ENT-1:0] hit_vec
);

   // R7
   dec_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (dec_valid == $past(da_valid)));

   // R7
   quiet_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_accept);

   // R5
   unicast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !da_mc) |=> dec_accept);

   // R6
   empty_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && da_mc && (entry_en == '0)) |=> !dec_accept);

   // R4
   miss_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && da_mc && (hit_vec == '0)) |=> !dec_accept);

   // R4
   hit_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && da_mc && (hit_vec != '0)) |=> dec_accept);

   // R10
   hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec & ~entry_en) == '0);

endmodule

bind mcast_addr_screen mcast_addr_screen_chk #(.N_ENT(N_ENT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .da_valid   (da_valid),
   .da_mc      (da[MC_BIT]),
   .dec_valid  (dec_valid),
   .dec_accept (dec_accept),
   .entry_en   (entry_en),
   .hit_vec    (hit_vec)
);

// File: tb/mcast_addr_screen_test.sv
module mcast_addr_screen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [5:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        da_valid = 1'b0;
   logic [47:0] da = '0;
   logic        dec_valid;
   logic        dec_accept;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   mcast_addr_screen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_idx    (cfg_idx),
      .cfg_wdata  (cfg_wdata),
      .rd_idx     (rd_idx),
      .rd_data    (rd_data),
      .da_valid   (da_valid),
      .da         (da),
      .dec_valid  (dec_valid),
      .dec_accept (dec_accept)
   );

   task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] idx, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] idx, input logic [31:0] exp);
      @(negedge clk);
      rd_idx = idx;
      #1;
      check(req, {16'h0, rd_data}, {16'h0, exp});
   endtask

   task automatic prog(input int e, input logic [47:0] a, input logic [47:0] m);
      wr(6'(e),      a[31:0]);
      wr(6'(8 + e),  {16'h0, a[47:32]});
      wr(6'(16 + e), m[31:0]);
      wr(6'(24 + e), {16'h0, m[47:32]});
   endtask

   task automatic lookup(input string req, input logic [47:0] addr, input logic exp);
      @(negedge clk);
      da = addr; da_valid = 1'b1;
      @(negedge clk);
      da_valid = 1'b0;
      check({req, " valid"}, 48'(dec_valid), 48'(1'b1));
      check({req, " accept"}, 48'(dec_accept), 48'(exp));
   endtask

   task automatic t_reset;
      check("R1 dec_valid", 48'(dec_valid), 48'h0);
      check("R1 dec_accept", 48'(dec_accept), 48'h0);
      rd_chk("R1 addr lo e0", 6'd0, 32'h0);
      rd_chk("R1 mask hi e7", 6'd31, 32'h0);
      rd_chk("R1 enable", 6'd32, 32'h0);
      lookup("R6 empty table mcast", 48'h01005E000000, 1'b0);
      lookup("R5 unicast on empty table", 48'h001122334455, 1'b1);
   endtask

   task automatic t_regmap;
      wr(6'd3,  32'hDEADBEEF);
      wr(6'd11, 32'hABCD1234);
      wr(6'd19, 32'h0F0F00FF);
      wr(6'd27, 32'h5555FFFF);
      wr(6'd32, 32'h000001A5);
      rd_chk("R2 addr lo e3", 6'd3,  32'hDEADBEEF);
      rd_chk("R2 addr hi e3 trunc", 6'd11, 32'h00001234);
      rd_chk("R2 mask lo e3", 6'd19, 32'h0F0F00FF);
      rd_chk("R2 mask hi e3 trunc", 6'd27, 32'h0000FFFF);
      rd_chk("R2 enable trunc", 6'd32, 32'h000000A5);
      rd_chk("R2 other entry untouched", 6'd4, 32'h0);
      prog(3, 48'h0, 48'h0);
      wr(6'd32, 32'h0);
   endtask

   task automatic t_example;
      prog(0, 48'h01005E000000, 48'hFFFFFFFFFFFF);
      wr(6'd32, 32'h1);
      lookup("R9 exact match", 48'h01005E000000, 1'b1);
      lookup("R9 one bit off", 48'h01005E000001, 1'b0);
      lookup("R4 other group", 48'h01005F000000, 1'b0);
   endtask

   task automatic t_mask;
      prog(2, 48'h01005E000000, 48'hFFFFFF800000);
      wr(6'd32, 32'h4);
      lookup("R3 range top", 48'h01005E7FFFFF, 1'b1);
      lookup("R3 range mid", 48'h01005E12ABCD, 1'b1);
      lookup("R3 past range", 48'h01005E800000, 1'b0);
   endtask

   task automatic t_multi;
      prog(5, 48'h333300000001, 48'hFFFFFFFFFFFF);
      wr(6'd32, 32'h25);
      lookup("R4 entry 5 hit", 48'h333300000001, 1'b1);
      lookup("R4 entry 0 hit", 48'h01005E000000, 1'b1);
      lookup("R4 no entry hit", 48'h333300000002, 1'b0);
      wr(6'd32, 32'h20);
      lookup("R10 disabled entry 0", 48'h01005E000000, 1'b0);
      lookup("R10 entry 2 disabled", 48'h01005E000042, 1'b0);
   endtask

   task automatic t_unicast;
      lookup("R5 unicast", 48'h001122334455, 1'b1);
      lookup("R5 local unicast", 48'h0200DEADBEEF, 1'b1);
   endtask

   task automatic t_none;
      wr(6'd32, 32'h0);
      lookup("R6 no enable entry5 addr", 48'h333300000001, 1'b0);
      lookup("R6 no enable entry0 addr", 48'h01005E000000, 1'b0);
   endtask

   task automatic t_inflight;
      wr(6'd32, 32'h20);
      @(negedge clk);
      da = 48'h333300000001; da_valid = 1'b1;
      cfg_we = 1'b1; cfg_idx = 6'd32; cfg_wdata = 32'h0;
      @(negedge clk);
      da_valid = 1'b0; cfg_we = 1'b0;
      check("R8 same-cycle write ignored", 48'(dec_accept), 48'h1);
      lookup("R8 write applies next", 48'h333300000001, 1'b0);
   endtask

   task automatic t_b2b;
      wr(6'd32, 32'h01);
      @(negedge clk);
      da = 48'h01005E000000; da_valid = 1'b1;
      @(negedge clk);
      check("R7 first valid", 48'(dec_valid), 48'h1);
      check("R7 first accept", 48'(dec_accept), 48'h1);
      da = 48'h01005E000003;
      @(negedge clk);
      da_valid = 1'b0;
      check("R7 second valid", 48'(dec_valid), 48'h1);
      check("R7 second reject", 48'(dec_accept), 48'h0);
      @(negedge clk);
      check("R7 valid drops", 48'(dec_valid), 48'h0);
      check("R7 accept low idle", 48'(dec_accept), 48'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regmap;
      t_example;
      t_mask;
      t_multi;
      t_unicast;
      t_none;
      t_inflight;
      t_b2b;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule